// File: doc/BRIEF.md
# UART Receiver with Three-Entry FIFO

This block takes an asynchronous serial line and turns it into bytes. An external baud generator supplies a one-cycle tick 16 times per bit period. The receiver synchronises the line and detects a falling start edge. It confirms the start bit in the middle of the bit and then samples each data bit at its mid-point. Each frame carries 8 data bits, LSB first. A ninth bit follows when either extra-bit mode or parity mode is on, and a single stop bit closes the frame.

A frame whose stop bit reads high is placed in a three-entry queue, unless the queue is already full. The host sees the oldest entry on the read port at all times, and a read strobe removes it. A receive flag tells the host that data has arrived. The host cannot clear that flag while entries remain, so software that drains with the clear, read, re-check loop never misses a byte. A multiprocessor mode holds the flag low for frames whose ninth bit is 0. Overrun and parity errors are held in sticky flags, and each is cleared by its own strobe.

Top module: `serial_rx_fifo3`

## Requirements
- R1: A new frame can begin only while `rx_en` is 1. A frame sent while `rx_en` is 0 stores nothing and leaves `rx_flag` at 0.
- R2: A low pulse on `rx` that has ended before the middle of the start bit (8 ticks after the edge) is rejected as noise. It stores nothing, and the next real frame is received correctly.
- R3: Data bits arrive LSB first, at 16 ticks per bit. `rd_data` always shows the oldest stored byte, and shows 0 when the queue is empty. A one-cycle `rd_stb` removes that byte, and from the next cycle on the following byte appears.
- R4: The queue holds 3 entries. A frame with a good stop bit that arrives while the queue is full is dropped, and `ovr_flag` is set. `ovr_flag` stays 1 until an `ovr_clr` strobe.
- R5: A frame whose stop bit samples low is not stored. It does not set `rx_flag` and does not set `ovr_flag`.
- R6: Storing a byte sets `rx_flag`. With `mp_en` set, the flag is set only when the stored extra bit is 1, but the byte is stored either way.
- R7: A `flag_clr` strobe clears `rx_flag` only if the queue is empty in that cycle. Otherwise the flag stays 1.
- R8: Each entry keeps its own extra bit. With `extra_en`=1 and `par_en`=0, `rd_xbit` shows the received ninth bit of the oldest entry. In every other mode it shows that entry's stop bit, which is 1.
- R9: With `par_en`=1, the ninth bit is compared with the parity selected by `par_type`. The encodings are 00 odd (the total count of ones is odd), 01 even, 10 always 1, and 11 always 0. A mismatch sets `perr_flag`, which stays set until `perr_clr`. The byte is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling tick, 16 per bit period |
| rx | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Allows new frames to start |
| extra_en | input | 1 | Ninth bit present and read back as data |
| par_en | input | 1 | Ninth bit is a checked parity bit |
| par_type | input | 2 | Parity kind: 00 odd, 01 even, 10 mark, 11 space |
| mp_en | input | 1 | Multiprocessor mode: flag only when extra bit is 1 |
| rd_stb | input | 1 | Removes the oldest entry |
| flag_clr | input | 1 | Request to clear the receive flag |
| ovr_clr | input | 1 | Clears the overrun flag |
| perr_clr | input | 1 | Clears the parity-error flag |
| rd_data | output | 8 | Oldest stored byte, or 0 when empty |
| rd_xbit | output | 1 | Extra or stop bit of the oldest entry |
| rx_flag | output | 1 | Receive flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| perr_flag | output | 1 | Sticky parity-error flag |

## Verification
The assertions rely on three assumptions. The mode inputs (`extra_en`, `par_en`, `par_type`, `mp_en`) do not change while a frame is being received. The tick is a single-cycle pulse. A read strobe never falls in the same cycle as a completed frame arriving at a full queue. The stimulus respects all three: it changes modes only while the line has been idle for at least one bit time, it issues reads and clear strobes only in the idle gap after a frame, and it takes the tick from a free-running divider.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        FE_IDLE  = 2'd0,
        FE_START = 2'd1,
        FE_DATA  = 2'd2,
        FE_STOP  = 2'd3
    } fe_state_e;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_kind_e;

    // Expected parity bit given the XOR of the data bits.
    function automatic logic par_expect(input logic data_odd, input par_kind_e kind);
        logic r;
        unique case (kind)
            PAR_ODD:   r = ~data_odd;
            PAR_EVEN:  r = data_odd;
            PAR_MARK:  r = 1'b1;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/srx_front.sv
module srx_front
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic              rx_en,
    input  logic              nine_en,
    output logic              frm_done,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_ninth,
    output logic              frm_stop
);

    localparam int SH_W  = DATA_W + 1;
    localparam int PH_W  = $clog2(OSR);
    localparam int IDX_W = $clog2(SH_W + 1);
    localparam logic [PH_W-1:0]  PH_MID = PH_W'(OSR / 2 - 1);
    localparam logic [PH_W-1:0]  PH_END = PH_W'(OSR - 1);
    localparam logic [IDX_W-1:0] LAST8  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] LAST9  = IDX_W'(DATA_W);

    typedef struct packed {
        fe_state_e         st;
        logic [PH_W-1:0]   ph;
        logic [IDX_W-1:0]  idx;
        logic [SH_W-1:0]   shf;
        logic              nine;
        logic              rx_m;
        logic              rx_s;
        logic              rx_p;
        logic              done;
        logic [DATA_W-1:0] data;
        logic              ninth;
        logic              stop;
    } fe_t;

    fe_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.rx_m = rx;
        d.rx_s = q.rx_m;
        d.rx_p = q.rx_s;
        unique case (q.st)
            FE_IDLE: begin
                if (rx_en && q.rx_p && !q.rx_s) begin
                    d.st = FE_START;
                    d.ph = '0;
                end
            end
            FE_START: begin
                if (tick) begin
                    if (q.ph == PH_MID) begin
                        d.ph = '0;
                        if (q.rx_s) begin
                            d.st = FE_IDLE;
                        end else begin
                            d.st   = FE_DATA;
                            d.idx  = '0;
                            d.nine = nine_en;
                        end
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
            end
            FE_DATA: begin
                if (tick) begin
                    if (q.ph == PH_END) begin
                        d.ph  = '0;
                        d.shf = {q.rx_s, q.shf[SH_W-1:1]};
                        d.idx = q.idx + 1'b1;
                        if (q.idx == (q.nine ? LAST9 : LAST8)) begin
                            d.st = FE_STOP;
                        end
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (q.ph == PH_END) begin
                        d.ph    = '0;
                        d.st    = FE_IDLE;
                        d.done  = 1'b1;
                        d.stop  = q.rx_s;
                        d.data  = q.nine ? q.shf[DATA_W-1:0] : q.shf[SH_W-1:1];
                        d.ninth = q.nine ? q.shf[SH_W-1] : 1'b0;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= FE_IDLE;
            q.rx_m  <= 1'b1;
            q.rx_s  <= 1'b1;
            q.rx_p  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign frm_done  = q.done;
    assign frm_data  = q.data;
    assign frm_ninth = q.ninth;
    assign frm_stop  = q.stop;

endmodule

// File: rtl/srx_queue.sv
module srx_queue #(
    parameter int W     = 9,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        head;
        logic [PTR_W-1:0]        tail;
        logic [CNT_W-1:0]        cnt;
    } qs_t;

    qs_t q, d;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    logic do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CNT_FULL);
        do_pop  = pop && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.tail] = wdata;
            d.tail        = bump(q.tail);
        end
        if (do_pop) begin
            d.head = bump(q.head);
        end
        unique case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CNT_FULL);
    assign rdata = empty ? '0 : q.mem[q.head];

endmodule

// File: rtl/serial_rx_fifo3.sv
module serial_rx_fifo3
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic              rx_en,
    input  logic              extra_en,
    input  logic              par_en,
    input  logic [1:0]        par_type,
    input  logic              mp_en,
    input  logic              rd_stb,
    input  logic              flag_clr,
    input  logic              ovr_clr,
    input  logic              perr_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_xbit,
    output logic              rx_flag,
    output logic              ovr_flag,
    output logic              perr_flag
);

    localparam int ENT_W = DATA_W + 1;

    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_ninth;
    logic              frm_stop;

    logic              push;
    logic              push_xbit;
    logic [ENT_W-1:0]  fifo_rdata;
    logic              fifo_full;
    logic              fifo_empty;

    srx_front #(
        .DATA_W (DATA_W),
        .OSR    (OSR)
    ) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx        (rx),
        .rx_en     (rx_en),
        .nine_en   (extra_en | par_en),
        .frm_done  (frm_done),
        .frm_data  (frm_data),
        .frm_ninth (frm_ninth),
        .frm_stop  (frm_stop)
    );

    srx_queue #(
        .W     (ENT_W),
        .DEPTH (DEPTH)
    ) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata ({push_xbit, frm_data}),
        .pop   (rd_stb),
        .rdata (fifo_rdata),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    typedef struct packed {
        logic rxf;
        logic ovr;
        logic perr;
    } flags_t;

    flags_t q, d;
    logic   good_frame;
    logic   ovr_hit;
    logic   perr_hit;
    logic   flag_set;

    always_comb begin
        good_frame = frm_done && frm_stop;
        push       = good_frame && !fifo_full;
        ovr_hit    = good_frame && fifo_full;
        push_xbit  = (extra_en && !par_en) ? frm_ninth : frm_stop;
        perr_hit   = good_frame && par_en &&
                     (frm_ninth != par_expect(^frm_data, par_kind_e'(par_type)));
        flag_set   = push && (!mp_en || push_xbit);

        d      = q;
        d.rxf  = flag_set || (q.rxf && !(flag_clr && fifo_empty));
        d.ovr  = ovr_hit  || (q.ovr && !ovr_clr);
        d.perr = perr_hit || (q.perr && !perr_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data   = fifo_rdata[DATA_W-1:0];
    assign rd_xbit   = fifo_rdata[DATA_W];
    assign rx_flag   = q.rxf;
    assign ovr_flag  = q.ovr;
    assign perr_flag = q.perr;

endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic clk,
    input logic rst_n,
    input logic rd_stb,
    input logic flag_clr,
    input logic ovr_clr,
    input logic perr_clr,
    input logic mp_en,
    input logic frm_done,
    input logic frm_stop,
    input logic push,
    input logic push_xbit,
    input logic fifo_full,
    input logic fifo_empty,
    input logic rx_flag,
    input logic ovr_flag,
    input logic perr_flag
);

    // R7: the flag may only fall after a clear request on an empty queue
    p_flag_clr_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_flag) |-> ($past(fifo_empty) && $past(flag_clr)));

    // R4: overrun stays set until its clear strobe
    p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    // R4: a good frame at a full queue raises overrun
    p_ovr_on_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_stop && fifo_full) |=> ovr_flag);

    // R4: a full queue stays full without a read
    p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !rd_stb) |=> fifo_full);

    // R9: parity error stays set until its clear strobe
    p_perr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_flag && !perr_clr) |=> perr_flag);

    // R5: a bad stop bit leaves an empty queue empty
    p_badstop_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && frm_done && !frm_stop) |=> fifo_empty);

    // R6: storing outside the suppressed case raises the flag
    p_flag_on_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && (!mp_en || push_xbit)) |=> rx_flag);

    // R6: a suppressed store leaves the flag unchanged
    p_mp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && mp_en && !push_xbit && !flag_clr) |=> (rx_flag == $past(rx_flag)));

    // R3: a store always leaves the queue non-empty
    p_store_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !fifo_empty);

endmodule

bind serial_rx_fifo3 srx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb     (rd_stb),
    .flag_clr   (flag_clr),
    .ovr_clr    (ovr_clr),
    .perr_clr   (perr_clr),
    .mp_en      (mp_en),
    .frm_done   (frm_done),
    .frm_stop   (frm_stop),
    .push       (push),
    .push_xbit  (push_xbit),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .rx_flag    (rx_flag),
    .ovr_flag   (ovr_flag),
    .perr_flag  (perr_flag)
);

// File: tb/serial_rx_fifo3_test.sv
module serial_rx_fifo3_test;

    localparam int CLK_NS   = 10;
    localparam int BIT_CLKS = 32;   // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic       rx_en = 1'b0;
    logic       extra_en = 1'b0;
    logic       par_en = 1'b0;
    logic [1:0] par_type = 2'b00;
    logic       mp_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic       flag_clr = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       perr_clr = 1'b0;
    logic [7:0] rd_data;
    logic       rd_xbit;
    logic       rx_flag;
    logic       ovr_flag;
    logic       perr_flag;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= ~tick;
    end

    serial_rx_fifo3 uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx        (rx),
        .rx_en     (rx_en),
        .extra_en  (extra_en),
        .par_en    (par_en),
        .par_type  (par_type),
        .mp_en     (mp_en),
        .rd_stb    (rd_stb),
        .flag_clr  (flag_clr),
        .ovr_clr   (ovr_clr),
        .perr_clr  (perr_clr),
        .rd_data   (rd_data),
        .rd_xbit   (rd_xbit),
        .rx_flag   (rx_flag),
        .ovr_flag  (ovr_flag),
        .perr_flag (perr_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rx = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit has9, input bit b9, input bit stp);
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(d[i]);
        if (has9) hold_bit(b9);
        hold_bit(stp);
        rx = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
    endtask

    task automatic pulse_read(output logic [7:0] d, output logic x);
        @(negedge clk);
        d = rd_data;
        x = rd_xbit;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
    endtask

    function automatic bit exp_par(input logic [7:0] d, input logic [1:0] k);
        int ones = $countones(d);
        case (k)
            2'b00:   return (ones % 2 == 0);
            2'b01:   return (ones % 2 == 1);
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic t_reset();
        check("R3 reset rd_data", rd_data, 0);
        check("R6 reset rx_flag", rx_flag, 0);
        check("R4 reset ovr_flag", ovr_flag, 0);
        check("R9 reset perr_flag", perr_flag, 0);
    endtask

    task automatic t_basic();
        logic [7:0] d; logic x;
        send_frame(8'hA5, 0, 0, 1);
        check("R6 flag after store", rx_flag, 1);
        check("R3 oldest byte LSB first", rd_data, 8'hA5);
        check("R8 xbit shows stop bit", rd_xbit, 1);
        pulse_read(d, x);
        check("R3 read value", d, 8'hA5);
        check("R3 empty reads zero", rd_data, 0);
        pulse_clr();
        check("R7 clear on empty", rx_flag, 0);
    endtask

    task automatic t_rxen();
        rx_en = 1'b0;
        send_frame(8'h3C, 0, 0, 1);
        check("R1 disabled no flag", rx_flag, 0);
        check("R1 disabled no data", rd_data, 0);
        rx_en = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic t_noise();
        logic [7:0] d; logic x;
        @(negedge clk);
        rx = 1'b0;
        repeat (6) @(negedge clk);
        rx = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        check("R2 glitch no flag", rx_flag, 0);
        check("R2 glitch no data", rd_data, 0);
        send_frame(8'h5A, 0, 0, 1);
        check("R2 frame after glitch", rd_data, 8'h5A);
        pulse_read(d, x);
        pulse_clr();
    endtask

    task automatic t_fifo();
        logic [7:0] d; logic x;
        send_frame(8'h11, 0, 0, 1);
        send_frame(8'h22, 0, 0, 1);
        send_frame(8'h33, 0, 0, 1);
        pulse_clr();
        check("R7 clear blocked while full", rx_flag, 1);
        check("R4 no overrun at three", ovr_flag, 0);
        send_frame(8'h44, 0, 0, 1);
        check("R4 overrun on fourth", ovr_flag, 1);
        pulse_read(d, x);
        check("R3 first out", d, 8'h11);
        check("R3 next appears", rd_data, 8'h22);
        pulse_read(d, x);
        pulse_clr();
        check("R7 clear blocked one left", rx_flag, 1);
        pulse_read(d, x);
        check("R4 fourth byte dropped", d, 8'h33);
        check("R4 queue empty after three", rd_data, 0);
        check("R4 overrun sticky", ovr_flag, 1);
        pulse_clr();
        check("R7 clear after drain", rx_flag, 0);
        @(negedge clk); ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
        check("R4 overrun cleared", ovr_flag, 0);
    endtask

    task automatic t_badstop();
        send_frame(8'h77, 0, 0, 0);
        repeat (BIT_CLKS) @(negedge clk);
        check("R5 bad stop no flag", rx_flag, 0);
        check("R5 bad stop no data", rd_data, 0);
        check("R5 bad stop no overrun", ovr_flag, 0);
    endtask

    task automatic t_extra();
        logic [7:0] d; logic x;
        extra_en = 1'b1;
        send_frame(8'h81, 1, 0, 1);
        send_frame(8'h82, 1, 1, 1);
        check("R8 ninth bit zero", rd_xbit, 0);
        check("R8 data with ninth", rd_data, 8'h81);
        pulse_read(d, x);
        check("R8 ninth bit one aligned", rd_xbit, 1);
        check("R8 second data", rd_data, 8'h82);
        pulse_read(d, x);
        pulse_clr();
        extra_en = 1'b0;
    endtask

    task automatic t_mp();
        logic [7:0] d; logic x;
        extra_en = 1'b1;
        mp_en = 1'b1;
        send_frame(8'h10, 1, 0, 1);
        check("R6 mp suppresses flag", rx_flag, 0);
        check("R6 mp byte still stored", rd_data, 8'h10);
        pulse_read(d, x);
        send_frame(8'h20, 1, 1, 1);
        check("R6 mp address flag", rx_flag, 1);
        pulse_read(d, x);
        pulse_clr();
        mp_en = 1'b0;
        extra_en = 1'b0;
    endtask

    task automatic t_parity();
        logic [7:0] d; logic x;
        par_en = 1'b1;
        extra_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            bit good;
            par_type = 2'(k);
            good = exp_par(8'h96, 2'(k));
            send_frame(8'h96, 1, good, 1);
            check($sformatf("R9 good parity type %0d", k), perr_flag, 0);
            check($sformatf("R9 readback stop type %0d", k), rd_xbit, 1);
            pulse_read(d, x);
            good = exp_par(8'h07, 2'(k));
            send_frame(8'h07, 1, !good, 1);
            check($sformatf("R9 bad parity type %0d", k), perr_flag, 1);
            check($sformatf("R9 bad byte stored type %0d", k), rd_data, 8'h07);
            pulse_read(d, x);
            pulse_clr();
            @(negedge clk); perr_clr = 1'b1; @(negedge clk); perr_clr = 1'b0; @(negedge clk);
            check($sformatf("R9 perr cleared type %0d", k), perr_flag, 0);
        end
        par_en = 1'b0;
        extra_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        rx_en = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
        t_basic();
        t_rxen();
        t_noise();
        t_fifo();
        t_badstop();
        t_extra();
        t_mp();
        t_parity();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_NS * 180000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule